// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between a synchronous request port inside the chip and an external asynchronous static RAM with a 19-bit address, a byte-wide data bus, a pair of chip selects of opposite polarity, an active-low write strobe and an active-low output enable. A request is one read or one write. It is accepted with a valid/ready handshake. The controller then sequences the RAM strobes so that the pulse width, the setup windows and the cycle time are all met. Every nanosecond limit becomes a cycle count: the limit is divided by the clock period and rounded up, so any nonzero limit costs at least one cycle.

The data pins are split into a drive value, a drive enable and a sampled input, so that the tristate pad can live at the chip edge. A write holds both selects active for the whole pulse and drives the byte only while the write strobe is low. A read opens the output enable for the longest access delay, samples the pins in the last cycle and returns the byte with a one-cycle valid pulse. When a write follows a read, the controller waits for the RAM outputs to float before it drives the bus.

The state machine has six states. `ST_IDLE` is ready. `ST_GAP` holds a write until the bus has floated. `ST_WPULSE` keeps the write strobe low. `ST_WHOLD` drives data after the strobe rises. `ST_WRECOV` fills out the write cycle time. `ST_RACCESS` keeps the output enable open.

The transitions are:
- Idle to access: a read request.
- Idle to gap: a write request while the turnaround is still pending.
- Idle or gap to pulse: a write request once the bus has floated.
- Pulse to hold, to recovery or to idle: the pulse count has expired.
- Hold to recovery or to idle: the hold count has expired.
- Recovery to idle: the recovery count has expired.
- Access to idle: the access count has expired. This is the transition that samples the read data.

Top module: `asram_bus_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, the primary select is high, the secondary select is low, the write strobe is high, the output enable is high, the drive enable is low, ready is high and rd_valid is low.
- R2: A request is taken on a clock edge where req_valid and req_ready are both high. Ready is low on the next cycle. No strobe and no drive are active while ready is high.
- R3: Every write holds the write strobe low for exactly P consecutive cycles, with both selects active and the output enable high throughout. P is the largest of ceil(pulse), ceil(address-to-end), ceil(select-to-end) and ceil(data-setup), where ceil(x) means x divided by the clock period and rounded up, with at least 1 for a nonzero x. P is 6 with the defaults.
- R4: The drive enable is high only while the write strobe is low or during the hold cycles, of which there are 0 with the defaults. It is never high while the output enable is low. While it is high, the drive value equals the byte of the accepted request.
- R5: A read holds both selects active, the output enable low and the write strobe high for exactly ceil(max(read cycle, address access, select access, enable access)) cycles, which is 7 with the defaults. The pins are sampled in the last of these cycles. rd_valid is high for exactly one cycle, on the cycle ready returns, and rd_data carries the sampled byte.
- R6: After a read, the drive enable rises no earlier than H clock edges after the edge on which the output enable rose, where H = ceil(float time) (3). A write requested d idle cycles after a read finishes keeps ready low for W + max(H-1-d, 0) cycles.
- R7: A write that needs no turnaround keeps ready low for W = max(ceil(write cycle), P + hold) cycles after acceptance (7).
- R8: The address and write byte are latched at acceptance. Changes on the request inputs while busy are ignored. The RAM address stays constant while a select is active.
- R9: A read that directly follows a write takes no extra cycles and returns the byte just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Request address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle read return pulse |
| rd_data | output | 8 | Read byte |
| ram_addr | output | 19 | RAM address |
| ram_cs_n | output | 1 | Primary select, active low |
| ram_cs | output | 1 | Secondary select, active high |
| ram_we_n | output | 1 | Write strobe, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_dq_out | output | 8 | Value to drive on the data pins |
| ram_dq_oe | output | 1 | Drive enable for the data pins |
| ram_dq_in | input | 8 | Value sampled from the data pins |

## Verification
Two functions can land in the same cycle: the float wait that follows a read, and the acceptance of a write. The first cycles after a read are still inside the float window, so a write accepted there must park in the gap state. The bench provokes this overlap by issuing writes zero to three idle cycles after a read has finished. It judges each case by the exact busy length and by a monitor that counts cycles since the output enable rose whenever the drive enable is high. The second overlap is the read return and the next acceptance. rd_valid and ready coincide, and a request is issued on that same cycle with no idle gap.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_WPULSE,
        ST_WHOLD,
        ST_WRECOV,
        ST_RACCESS
    } asram_state_t;

    // Round a nanosecond limit up to whole clock cycles.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        if (ns <= 0) return 0;
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_turnaround.sv
module asram_turnaround #(
    parameter int HZ_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_done,
    output logic hz_clear
);
    localparam int HW = $clog2(HZ_CYC + 2);

    logic [HW-1:0] hz_left;

    // Counts down the float time once the output enable closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hz_left <= '0;
        end else if (rd_done) begin
            hz_left <= HW'(HZ_CYC);
        end else if (hz_left != '0) begin
            hz_left <= hz_left - 1'b1;
        end
    end

    // A drive starting on the next edge is then at least HZ_CYC edges late.
    assign hz_clear = (hz_left <= HW'(1));

    AST_HZ_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_done |=> (hz_left <= HW'(HZ_CYC)));                        // R6

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              wr_drive,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            rd_valid <= rd_done;
            if (rd_done) begin
                rd_data <= dq_in;
            end
        end
    end

    assign ram_addr = addr_q;
    assign dq_out   = wdata_q;
    assign dq_oe    = wr_drive;

    AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);                                       // R5

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
    import asram_pkg::*;
#(
    parameter int WP_CYC   = 6,
    parameter int HOLD_CYC = 0,
    parameter int REC_CYC  = 1,
    parameter int RD_CYC   = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic hz_clear,
    output logic req_ready,
    output logic accept,
    output logic rd_done,
    output logic cs_act,
    output logic we_act,
    output logic oe_act,
    output logic wr_drive
);
    localparam int CMAX  = imax(imax(WP_CYC, HOLD_CYC), imax(REC_CYC, RD_CYC));
    localparam int CNT_W = $clog2(CMAX + 1);

    asram_state_t     state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Transitions.
    always_comb begin
        state_nxt = state;
        cnt_nxt   = (cnt == '0) ? '0 : cnt - 1'b1;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_write) begin
                        state_nxt = ST_RACCESS;
                        cnt_nxt   = CNT_W'(RD_CYC - 1);
                    end else if (!hz_clear) begin
                        state_nxt = ST_GAP;
                    end else begin
                        state_nxt = ST_WPULSE;
                        cnt_nxt   = CNT_W'(WP_CYC - 1);
                    end
                end
            end
            ST_GAP: begin
                if (hz_clear) begin
                    state_nxt = ST_WPULSE;
                    cnt_nxt   = CNT_W'(WP_CYC - 1);
                end
            end
            ST_WPULSE: begin
                if (cnt == '0) begin
                    if (HOLD_CYC > 0) begin
                        state_nxt = ST_WHOLD;
                        cnt_nxt   = CNT_W'(imax(HOLD_CYC - 1, 0));
                    end else if (REC_CYC > 0) begin
                        state_nxt = ST_WRECOV;
                        cnt_nxt   = CNT_W'(imax(REC_CYC - 1, 0));
                    end else begin
                        state_nxt = ST_IDLE;
                    end
                end
            end
            ST_WHOLD: begin
                if (cnt == '0) begin
                    if (REC_CYC > 0) begin
                        state_nxt = ST_WRECOV;
                        cnt_nxt   = CNT_W'(imax(REC_CYC - 1, 0));
                    end else begin
                        state_nxt = ST_IDLE;
                    end
                end
            end
            ST_WRECOV: begin
                if (cnt == '0) state_nxt = ST_IDLE;
            end
            ST_RACCESS: begin
                if (cnt == '0) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        req_ready = 1'b0;
        cs_act    = 1'b0;
        we_act    = 1'b0;
        oe_act    = 1'b0;
        wr_drive  = 1'b0;
        rd_done   = 1'b0;
        unique case (state)
            ST_IDLE:    req_ready = 1'b1;
            ST_GAP:     ;
            ST_WPULSE: begin
                cs_act   = 1'b1;
                we_act   = 1'b1;
                wr_drive = 1'b1;
            end
            ST_WHOLD: begin
                cs_act   = 1'b1;
                wr_drive = 1'b1;
            end
            ST_WRECOV:  ;
            ST_RACCESS: begin
                cs_act  = 1'b1;
                oe_act  = 1'b1;
                rd_done = (cnt == '0);
            end
            default:    ;
        endcase
        accept = req_ready && req_valid;
    end

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);                                        // R2

    AST_GAP_ONLY_FOR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> $past(req_write || state == ST_GAP));    // R6

endmodule

// File: rtl/asram_bus_ctrl.sv
module asram_bus_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 10,
    parameter int T_WC_NS   = 70,
    parameter int T_WP_NS   = 55,
    parameter int T_AW_NS   = 60,
    parameter int T_CW_NS   = 60,
    parameter int T_DW_NS   = 30,
    parameter int T_DH_NS   = 0,
    parameter int T_RC_NS   = 70,
    parameter int T_AA_NS   = 70,
    parameter int T_CO_NS   = 70,
    parameter int T_OE_NS   = 35,
    parameter int T_HZ_NS   = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_cs_n,
    output logic              ram_cs,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in
);
    localparam int WP_CYC   = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                                   imax(imax(ns_to_cyc(T_CW_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)), 1));
    localparam int HOLD_CYC = ns_to_cyc(T_DH_NS, CLK_NS);
    localparam int REC_CYC  = imax(ns_to_cyc(T_WC_NS, CLK_NS) - WP_CYC - HOLD_CYC, 0);
    localparam int RD_CYC   = imax(imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                   imax(imax(ns_to_cyc(T_CO_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)), 1));
    localparam int HZ_CYC   = ns_to_cyc(T_HZ_NS, CLK_NS);

    logic accept, rd_done, hz_clear;
    logic cs_act, we_act, oe_act, wr_drive;

    asram_fsm #(
        .WP_CYC   (WP_CYC),
        .HOLD_CYC (HOLD_CYC),
        .REC_CYC  (REC_CYC),
        .RD_CYC   (RD_CYC)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .hz_clear  (hz_clear),
        .req_ready (req_ready),
        .accept    (accept),
        .rd_done   (rd_done),
        .cs_act    (cs_act),
        .we_act    (we_act),
        .oe_act    (oe_act),
        .wr_drive  (wr_drive)
    );

    asram_turnaround #(
        .HZ_CYC (HZ_CYC)
    ) i_turn (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_done  (rd_done),
        .hz_clear (hz_clear)
    );

    asram_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .wr_drive  (wr_drive),
        .rd_done   (rd_done),
        .dq_in     (ram_dq_in),
        .ram_addr  (ram_addr),
        .dq_out    (ram_dq_out),
        .dq_oe     (ram_dq_oe),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    assign ram_cs_n = ~cs_act;
    assign ram_cs   = cs_act;
    assign ram_we_n = ~we_act;
    assign ram_oe_n = ~oe_act;

    // Window counters for the timing checks.
    logic [7:0] we_len_q, since_oe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_len_q   <= '0;
            since_oe_q <= 8'hFF;
        end else begin
            we_len_q   <= ram_we_n ? 8'd0 : ((we_len_q == 8'hFF) ? 8'hFF : we_len_q + 8'd1);
            since_oe_q <= !ram_oe_n ? 8'd0 : ((since_oe_q == 8'hFF) ? 8'hFF : since_oe_q + 8'd1);
        end
    end

    AST_QUIET_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ram_cs_n && !ram_cs && ram_we_n && ram_oe_n && !ram_dq_oe)); // R2

    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (we_len_q == 8'(WP_CYC)));                 // R3

    AST_WE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (!ram_cs_n && ram_cs && ram_oe_n));               // R3

    AST_DRIVE_NOT_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_oe |-> ram_oe_n);                                       // R4

    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_oe |-> (since_oe_q >= 8'(HZ_CYC)));                     // R6

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_cs_n && $past(!ram_cs_n)) |-> $stable(ram_addr));        // R8

    AST_RD_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> req_ready);                                       // R5

endmodule

// File: tb/test_asram_bus_ctrl.sv
module test_asram_bus_ctrl;

    localparam int PER     = 10;
    localparam int WP_EXP  = 6;   // max of ceil(55,60,60,30 / 10)
    localparam int HOLD_EX = 0;
    localparam int WC_TOT  = 7;   // max(ceil(70/10), WP_EXP + HOLD_EX)
    localparam int RD_EXP  = 7;   // ceil(max(70,70,70,35) / 10)
    localparam int HZ_EXP  = 3;   // ceil(25/10)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [7:0]  rd_data;
    logic [18:0] ram_addr;
    logic        ram_cs_n, ram_cs, ram_we_n, ram_oe_n, ram_dq_oe;
    logic [7:0]  ram_dq_out, ram_dq_in;

    always #(PER/2) clk = ~clk;

    asram_bus_ctrl i_asram_bus_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .ram_addr   (ram_addr),
        .ram_cs_n   (ram_cs_n),
        .ram_cs     (ram_cs),
        .ram_we_n   (ram_we_n),
        .ram_oe_n   (ram_oe_n),
        .ram_dq_out (ram_dq_out),
        .ram_dq_oe  (ram_dq_oe),
        .ram_dq_in  (ram_dq_in)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // RAM model: the byte is valid only once the enable has been open long enough.
    logic [7:0]  ram_mem [0:63];
    logic [7:0]  exp_mem [0:63];
    int          oe_cnt = 0;
    int          since_oe = 1000;
    int          we_run = 0;
    logic        rd_ok = 1'b0;
    logic [18:0] cur_addr = '0;
    logic [7:0]  cur_data = '0;
    bit          prev_rd = 1'b0;

    assign ram_dq_in = rd_ok ? ram_mem[ram_addr[5:0]] : 8'h5A;

    initial begin
        for (int k = 0; k < 64; k++) begin
            ram_mem[k] = 8'h00;
            exp_mem[k] = 8'h00;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            oe_cnt   = ram_oe_n ? 0 : oe_cnt + 1;
            since_oe = ram_oe_n ? since_oe + 1 : 0;
            rd_ok    = (oe_cnt >= RD_EXP) && !ram_cs_n && ram_cs;
            if (!ram_we_n) begin
                we_run++;
                chk(!ram_cs_n && ram_cs && ram_oe_n, "R3 selects during write", {ram_cs_n, ram_cs, ram_oe_n}, 3'b011);
                chk(ram_dq_oe == 1'b1, "R4 drive while strobe low", ram_dq_oe, 1);
                chk(ram_dq_out == cur_data, "R4 drive value", ram_dq_out, cur_data);
                ram_mem[ram_addr[5:0]] = ram_dq_out;
            end else if (we_run != 0) begin
                chk(we_run == WP_EXP, "R3 write strobe width", we_run, WP_EXP);
                we_run = 0;
            end
            if (ram_dq_oe) begin
                chk(since_oe > HZ_EXP, "R6 drive after float time", since_oe, HZ_EXP + 1);
                chk(!ram_we_n || HOLD_EX > 0, "R4 drive outside pulse", ram_we_n, 0);
            end
            if (!ram_cs_n) begin
                chk(ram_addr == cur_addr, "R8 held address", ram_addr, cur_addr);
            end
        end
    end

    function automatic logic [18:0] mk_addr(input int i);
        return {13'(i * 4111 + 3), 6'(i)};
    endfunction

    function automatic logic [7:0] pat(input int i, input int ph);
        return 8'(i * 29 + 7 + ph * 53);
    endfunction

    task automatic do_op(input bit wr, input logic [18:0] a, input logic [7:0] d,
                         input int idle, input string tag);
        int busy;
        int exp_busy;
        repeat (idle) @(negedge clk);
        while (!req_ready) @(negedge clk);
        if (wr && prev_rd) exp_busy = WC_TOT + ((HZ_EXP - 1 - idle > 0) ? HZ_EXP - 1 - idle : 0);
        else if (wr)       exp_busy = WC_TOT;
        else               exp_busy = RD_EXP;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        cur_addr  = a;
        cur_data  = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = ~wr;
        req_addr  = ~a;
        req_wdata = ~d;
        busy = 0;
        while (!req_ready && busy < 100) begin
            busy++;
            if (rd_valid) chk(1'b0, "R5 rd_valid while busy", 1, 0);
            @(negedge clk);
        end
        if (wr) begin
            chk(busy == exp_busy, prev_rd ? "R6 write busy after read" : "R7 write busy", busy, exp_busy);
            exp_mem[a[5:0]] = d;
        end else begin
            chk(busy == exp_busy, "R5 read busy", busy, exp_busy);
            chk(rd_valid == 1'b1, "R5 rd_valid at ready", rd_valid, 1);
            chk(rd_data == exp_mem[a[5:0]], tag, rd_data, exp_mem[a[5:0]]);
        end
        prev_rd = !wr;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk({ram_cs_n, ram_cs, ram_we_n, ram_oe_n, ram_dq_oe} == 5'b10110, "R1 strobes in reset",
            {ram_cs_n, ram_cs, ram_we_n, ram_oe_n, ram_dq_oe}, 5'b10110);
        chk(req_ready && !rd_valid, "R1 ready in reset", {req_ready, rd_valid}, 2'b10);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({ram_cs_n, ram_cs, ram_we_n, ram_oe_n, ram_dq_oe} == 5'b10110, "R1 strobes after reset",
            {ram_cs_n, ram_cs, ram_we_n, ram_oe_n, ram_dq_oe}, 5'b10110);
        chk(req_ready && !rd_valid, "R2 ready idle", {req_ready, rd_valid}, 2'b10);

        for (int i = 0; i < 64; i++) do_op(1'b1, mk_addr(i), pat(i, 0), i % 3, "R7 write");
        for (int i = 0; i < 64; i++) do_op(1'b0, mk_addr(i), 8'h00, i % 2, "R5 read data");
        for (int i = 0; i < 64; i++) begin
            do_op(1'b0, mk_addr(i), 8'h00, i % 4, "R5 read before turnaround");
            do_op(1'b1, mk_addr(i), pat(i, 1), i % 4, "R6 write");
        end
        for (int i = 0; i < 32; i++) begin
            do_op(1'b1, mk_addr(i), pat(i, 2), 0, "R7 write");
            do_op(1'b0, mk_addr(i), 8'h00, 0, "R9 read after write");
        end
        for (int i = 0; i < 64; i++) do_op(1'b0, mk_addr(i), 8'h00, 0, "R8 final contents");

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule